// File: doc/BRIEF.md
# Windowed Access-Bank Address Remapper

This block turns a short file-register operand into a full 12-bit data-memory address and performs one byte access to a local data RAM. The data space has 16 banks of 256 bytes. Its top 128 bytes (F80h–FFFh) hold special registers. An access-select input chooses between two mappings. The banked mapping joins a 4-bit bank register with the 8-bit operand. The access-bank mapping sends operands 80h–FFh to the special-register region and operands 60h–7Fh to the same offsets in bank 0.

When the extended-instruction mode is enabled, the access-bank operands 00h–5Fh are not sent to bank 0. They land in a 96-byte window that starts at a 12-bit pointer register, so operand 05h reaches pointer + 05h. The sum wraps around the 4 KiB space. When the mode is off, those operands reach the bottom of bank 0 as usual. Special-register addresses are not decoded further: they are passed to the RAM like any other address.

The bank register, the two halves of the pointer and the mode flag each have a write strobe. All of them share one 8-bit configuration data bus. An access is presented with a valid strobe. Its address and write data are registered once, and read data for it appears in the following cycle. A write is committed at the end of that same cycle, which lets a caller read, modify and write back a location.

Top module: `accwin_remapper`

## Requirements
- R1: A synchronous active-high reset clears the bank register and the pointer to zero, disables extended mode and drops `rdValid`. After reset, access-bank operand 10h maps to 010h and banked operand 34h maps to 034h.
- R2: With `accSel`=1 the address is {bank[3:0], operand}, and the mode flag has no effect on it.
- R3: With `accSel`=0, extended mode on and operand below 60h, the address is pointer + operand.
- R4: The windowed sum wraps modulo 4096. With pointer FF0h, operand 20h gives 010h.
- R5: With `accSel`=0, operands 60h–7Fh map to 060h–07Fh whether the mode is on or off.
- R6: With `accSel`=0, operands 80h–FFh map to F80h–FFFh whether the mode is on or off.
- R7: With `accSel`=0 and extended mode off, operands 00h–5Fh map to 000h–05Fh.
- R8: With pointer 120h and the mode on, the window spans 120h–17Fh. Operand 5Fh gives 17Fh and operand 60h gives 060h. Bank 0 bytes below 60h can then be reached only with `accSel`=1.
- R9: `rdValid` and `rdAddr` show an access in the clock cycle after it is presented with `accValid`=1. In that cycle `rdData` holds the byte stored at `rdAddr` before the access.
- R10: A write (`accWrite`=1) stores `accWrData` at the mapped address at the end of the cycle after it is presented. An access presented in the very next cycle already reads the new value.
- R11: A configuration write in the same cycle as an access takes effect only from the next access on. The access itself uses the old bank, pointer or mode.
- R12: The bank register and the pointer high part take only `cfgData[3:0]`. The pointer low part takes all of `cfgData`, and the mode flag takes `cfgData[0]`. Bits 7:4 written to the bank register have no effect on addresses.
- R13: With `accValid`=0 nothing is written, even when `accWrite`=1, and in the next cycle `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgBankWe | input | 1 | Load the bank register from cfgData[3:0] |
| cfgPtrHiWe | input | 1 | Load pointer bits 11:8 from cfgData[3:0] |
| cfgPtrLoWe | input | 1 | Load pointer bits 7:0 from cfgData |
| cfgExtWe | input | 1 | Load the extended-mode flag from cfgData[0] |
| cfgData | input | 8 | Shared configuration write data |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSel | input | 1 | 1 = banked mapping, 0 = access-bank mapping |
| accOperand | input | 8 | File-register operand |
| accWrData | input | 8 | Byte to store on a write |
| rdValid | output | 1 | Registered access is being served this cycle |
| rdAddr | output | 12 | Mapped address of the registered access |
| rdData | output | 8 | Byte at rdAddr before any write in this cycle |

## Verification
Two things can fall into one cycle here. A configuration register may be written while an access that depends on it is presented, and a write may be committing while the next access to the same address is already being registered. The bench provokes the first by raising a pointer strobe in the same cycle as a windowed access. The address of that access must still reflect the old pointer, and the following access must reflect the new one. For the second, the bench issues a write and then a read of the same mapped location in back-to-back cycles, and expects the read to return the freshly written byte.

// File: rtl/accwin_pkg.sv
package accwin_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic bankLoad;
    logic ptrHiLoad;
    logic ptrLoLoad;
    logic extLoad;
    logic capture;   // latch address and write data into the stage
    logic memWrite;  // commit the staged write this cycle
  } accwin_ctrl_t;
endpackage

// File: rtl/accwin_ctrl.sv
module accwin_ctrl
  import accwin_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cfgBankWe,
  input  logic         cfgPtrHiWe,
  input  logic         cfgPtrLoWe,
  input  logic         cfgExtWe,
  input  logic         accValid,
  input  logic         accWrite,
  output accwin_ctrl_t ctrl,
  output logic         stageValid
);
  logic stageValidQ;
  logic stageWriteQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValidQ <= 1'b0;
      stageWriteQ <= 1'b0;
    end else begin
      stageValidQ <= accValid;
      stageWriteQ <= accValid & accWrite;
    end
  end

  always_comb begin
    ctrl.bankLoad  = cfgBankWe;
    ctrl.ptrHiLoad = cfgPtrHiWe;
    ctrl.ptrLoLoad = cfgPtrLoWe;
    ctrl.extLoad   = cfgExtWe;
    ctrl.capture   = accValid;
    ctrl.memWrite  = stageValidQ & stageWriteQ;
  end

  assign stageValid = stageValidQ;
endmodule

// File: rtl/accwin_addrgen.sv
module accwin_addrgen #(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int WIN_SIZE = 96
) (
  input  logic [ADDR_W-OPND_W-1:0] bank,
  input  logic [ADDR_W-1:0]        ptr,
  input  logic                     extEn,
  input  logic                     sel,
  input  logic [OPND_W-1:0]        operand,
  output logic [ADDR_W-1:0]        addr
);
  localparam int HI_W = ADDR_W - OPND_W;
  localparam logic [OPND_W-1:0] WinLimit = OPND_W'(WIN_SIZE);

  logic              inWindow;
  logic [ADDR_W-1:0] winAddr;

  assign inWindow = extEn && (operand < WinLimit);
  assign winAddr  = ptr + {{HI_W{1'b0}}, operand};

  always_comb begin
    if (sel)
      addr = {bank, operand};
    else if (inWindow)
      addr = winAddr;
    else if (operand[OPND_W-1])
      addr = {{HI_W{1'b1}}, operand};
    else
      addr = {{HI_W{1'b0}}, operand};
  end
endmodule

// File: rtl/accwin_datapath.sv
module accwin_datapath
  import accwin_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_SIZE = 96
) (
  input  logic               clk,
  input  logic               rst,
  input  accwin_ctrl_t       ctrl,
  input  logic [OPND_W-1:0]  cfgData,
  input  logic               accSel,
  input  logic [OPND_W-1:0]  accOperand,
  input  logic [DATA_W-1:0]  accWrData,
  output logic [ADDR_W-1:0]  stageAddr,
  output logic [DATA_W-1:0]  stageWrData
);
  localparam int HI_W = ADDR_W - OPND_W;

  logic [HI_W-1:0]   bankQ;
  logic [HI_W-1:0]   ptrHiQ;
  logic [OPND_W-1:0] ptrLoQ;
  logic              extQ;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] stageAddrQ;
  logic [DATA_W-1:0] stageDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankQ  <= '0;
      ptrHiQ <= '0;
      ptrLoQ <= '0;
      extQ   <= 1'b0;
    end else begin
      if (ctrl.bankLoad)  bankQ  <= cfgData[HI_W-1:0];
      if (ctrl.ptrHiLoad) ptrHiQ <= cfgData[HI_W-1:0];
      if (ctrl.ptrLoLoad) ptrLoQ <= cfgData;
      if (ctrl.extLoad)   extQ   <= cfgData[0];
    end
  end

  accwin_addrgen #(
    .ADDR_W  (ADDR_W),
    .OPND_W  (OPND_W),
    .WIN_SIZE(WIN_SIZE)
  ) u_addrgen (
    .bank   (bankQ),
    .ptr    ({ptrHiQ, ptrLoQ}),
    .extEn  (extQ),
    .sel    (accSel),
    .operand(accOperand),
    .addr   (mapAddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stageAddrQ <= '0;
      stageDataQ <= '0;
    end else if (ctrl.capture) begin
      stageAddrQ <= mapAddr;
      stageDataQ <= accWrData;
    end
  end

  assign stageAddr   = stageAddrQ;
  assign stageWrData = stageDataQ;
endmodule

// File: rtl/accwin_ram.sv
module accwin_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wrData;
  end

  // read of the staged address; shows the value before this cycle's write
  assign rdData = mem[addr];
endmodule

// File: rtl/accwin_remapper.sv
module accwin_remapper
  import accwin_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OPND_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_SIZE = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgBankWe,
  input  logic              cfgPtrHiWe,
  input  logic              cfgPtrLoWe,
  input  logic              cfgExtWe,
  input  logic [OPND_W-1:0] cfgData,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSel,
  input  logic [OPND_W-1:0] accOperand,
  input  logic [DATA_W-1:0] accWrData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  accwin_ctrl_t      ctrl;
  logic [ADDR_W-1:0] stageAddr;
  logic [DATA_W-1:0] stageWrData;

  accwin_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgBankWe (cfgBankWe),
    .cfgPtrHiWe(cfgPtrHiWe),
    .cfgPtrLoWe(cfgPtrLoWe),
    .cfgExtWe  (cfgExtWe),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .ctrl      (ctrl),
    .stageValid(rdValid)
  );

  accwin_datapath #(
    .ADDR_W  (ADDR_W),
    .OPND_W  (OPND_W),
    .DATA_W  (DATA_W),
    .WIN_SIZE(WIN_SIZE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .cfgData    (cfgData),
    .accSel     (accSel),
    .accOperand (accOperand),
    .accWrData  (accWrData),
    .stageAddr  (stageAddr),
    .stageWrData(stageWrData)
  );

  accwin_ram #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (ctrl.memWrite),
    .addr  (stageAddr),
    .wrData(stageWrData),
    .rdData(rdData)
  );

  assign rdAddr = stageAddr;
endmodule

// File: rtl/accwin_checker.sv
module accwin_checker #(
  parameter int ADDR_W = 12,
  parameter int OPND_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgExtWe,
  input logic [OPND_W-1:0] cfgData,
  input logic              accValid,
  input logic              accSel,
  input logic [OPND_W-1:0] accOperand,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr
);
  localparam int HI_W = ADDR_W - OPND_W;

  // mode flag as seen from the configuration port
  logic extSeen;
  always_ff @(posedge clk) begin
    if (rst) extSeen <= 1'b0;
    else if (cfgExtWe) extSeen <= cfgData[0];
  end

  // R1: reset empties the stage
  a_r1_reset_clears_valid: assert property (@(posedge clk) rst |=> !rdValid);

  // R9 / R13: valid follows the request by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    accValid |=> rdValid);
  a_r13_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !accValid |=> !rdValid);

  // R2: banked path keeps the operand as the low byte
  a_r2_banked_low: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSel) |=> rdAddr[OPND_W-1:0] == $past(accOperand));

  // R6: upper access-bank half lands in the special-register region
  a_r6_sfr_region: assert property (@(posedge clk) disable iff (rst)
    (accValid && !accSel && accOperand[OPND_W-1])
      |=> rdAddr == {{HI_W{1'b1}}, $past(accOperand)});

  // R5: 60h-7Fh go to bank 0 in both modes
  a_r5_mid_fixed: assert property (@(posedge clk) disable iff (rst)
    (accValid && !accSel && accOperand[OPND_W-1 -: 3] == 3'b011)
      |=> rdAddr == {{HI_W{1'b0}}, $past(accOperand)});

  // R7: with the mode off the low range is bank 0
  a_r7_plain_low: assert property (@(posedge clk) disable iff (rst)
    (accValid && !accSel && !extSeen && !accOperand[OPND_W-1])
      |=> rdAddr == {{HI_W{1'b0}}, $past(accOperand)});
endmodule

bind accwin_remapper accwin_checker #(
  .ADDR_W(ADDR_W),
  .OPND_W(OPND_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfgExtWe  (cfgExtWe),
  .cfgData   (cfgData),
  .accValid  (accValid),
  .accSel    (accSel),
  .accOperand(accOperand),
  .rdValid   (rdValid),
  .rdAddr    (rdAddr)
);

// File: tb/sim_accwin_remapper.sv
`timescale 1ns/1ps
module sim_accwin_remapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgBankWe = 0, cfgPtrHiWe = 0, cfgPtrLoWe = 0, cfgExtWe = 0;
  logic [7:0]  cfgData = '0;
  logic        accValid = 0, accWrite = 0, accSel = 0;
  logic [7:0]  accOperand = '0, accWrData = '0;
  logic        rdValid;
  logic [11:0] rdAddr;
  logic [7:0]  rdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [11:0] gotAddr;
  logic [7:0]  gotData;
  logic        gotValid;

  always #4 clk = ~clk;  // 125 MHz

  accwin_remapper u0 (
    .clk(clk), .rst(rst),
    .cfgBankWe(cfgBankWe), .cfgPtrHiWe(cfgPtrHiWe),
    .cfgPtrLoWe(cfgPtrLoWe), .cfgExtWe(cfgExtWe), .cfgData(cfgData),
    .accValid(accValid), .accWrite(accWrite), .accSel(accSel),
    .accOperand(accOperand), .accWrData(accWrData),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic access(input logic sel, input logic [7:0] op,
                        input logic wr, input logic [7:0] wd);
    accValid = 1; accSel = sel; accOperand = op; accWrite = wr; accWrData = wd;
    @(posedge clk); @(negedge clk);
    gotAddr = rdAddr; gotData = rdData; gotValid = rdValid;
    accValid = 0; accWrite = 0;
  endtask

  task automatic cfg(input int which, input logic [7:0] d);
    cfgData = d;
    case (which)
      0: cfgBankWe = 1;
      1: cfgPtrHiWe = 1;
      2: cfgPtrLoWe = 1;
      default: cfgExtWe = 1;
    endcase
    @(posedge clk); @(negedge clk);
    cfgBankWe = 0; cfgPtrHiWe = 0; cfgPtrLoWe = 0; cfgExtWe = 0;
  endtask

  task automatic setPtr(input logic [11:0] p);
    cfg(1, {4'h0, p[11:8]});
    cfg(2, p[7:0]);
  endtask

  task automatic t_reset;
    chk("R1 rdValid after reset", rdValid, 0);
    access(0, 8'h10, 0, 0);
    chk("R1 mode off after reset", gotAddr, 12'h010);
    access(1, 8'h34, 0, 0);
    chk("R1 bank zero after reset", gotAddr, 12'h034);
  endtask

  task automatic t_banked;
    cfg(0, 8'hA5);
    access(1, 8'h3C, 0, 0);
    chk("R12 bank upper bits ignored", gotAddr, 12'h53C);
    cfg(3, 8'h01);
    access(1, 8'h3C, 0, 0);
    chk("R2 banked with mode on", gotAddr, 12'h53C);
    chk("R9 rdValid one cycle later", gotValid, 1);
  endtask

  task automatic t_window;
    setPtr(12'h120);
    access(0, 8'h00, 0, 0); chk("R8 window base", gotAddr, 12'h120);
    access(0, 8'h5F, 0, 0); chk("R8 window top", gotAddr, 12'h17F);
    access(0, 8'h60, 0, 0); chk("R8 first fixed operand", gotAddr, 12'h060);
    access(0, 8'h2A, 0, 0); chk("R3 pointer plus operand", gotAddr, 12'h14A);
  endtask

  task automatic t_wrap;
    cfg(1, 8'hFF);  // only low nibble used (R12)
    cfg(2, 8'hF0);
    access(0, 8'h20, 0, 0); chk("R4 wrap modulo 4096", gotAddr, 12'h010);
    chk("R12 pointer high nibble", gotAddr, 12'h010);
  endtask

  task automatic t_fixed;
    access(0, 8'h7F, 0, 0); chk("R5 mid mode on", gotAddr, 12'h07F);
    access(0, 8'h80, 0, 0); chk("R6 sfr low mode on", gotAddr, 12'hF80);
    cfg(3, 8'h00);
    access(0, 8'h60, 0, 0); chk("R5 mid mode off", gotAddr, 12'h060);
    access(0, 8'hFF, 0, 0); chk("R6 sfr top mode off", gotAddr, 12'hFFF);
    access(0, 8'h5F, 0, 0); chk("R7 low top mode off", gotAddr, 12'h05F);
    access(0, 8'h00, 0, 0); chk("R7 low base mode off", gotAddr, 12'h000);
  endtask

  task automatic t_data;
    setPtr(12'h120);
    cfg(3, 8'h01);
    access(0, 8'h05, 1, 8'h3C);           // window write -> 125h
    cfg(0, 8'h00);
    access(1, 8'h05, 1, 8'h77);           // bank 0 byte 005h
    cfg(0, 8'h01);
    access(1, 8'h25, 0, 0);
    chk("R10 window write lands at 125h", gotData, 8'h3C);
    access(0, 8'h05, 0, 0);
    chk("R8 window hides bank 0", gotData, 8'h3C);
    cfg(3, 8'h00);
    access(0, 8'h05, 0, 0);
    chk("R8 bank 0 byte kept", gotData, 8'h77);
    // back-to-back write then read of same location
    access(0, 8'h40, 1, 8'h9E);
    access(0, 8'h40, 0, 0);
    chk("R10 next-cycle read sees write", gotData, 8'h9E);
    chk("R9 rdAddr of read", gotAddr, 12'h040);
    // read-modify-write: data shown is pre-write value
    access(0, 8'h40, 1, 8'h11);
    chk("R9 rdData before write", gotData, 8'h9E);
  endtask

  task automatic t_idle;
    cfg(0, 8'h02);
    access(1, 8'h00, 1, 8'hAA);
    accValid = 0; accWrite = 1; accSel = 1; accOperand = 8'h00; accWrData = 8'h55;
    @(posedge clk); @(negedge clk);
    chk("R13 no valid when idle", rdValid, 0);
    accWrite = 0;
    access(1, 8'h00, 0, 0);
    chk("R13 idle write ignored", gotData, 8'hAA);
  endtask

  task automatic t_same_cycle;
    setPtr(12'h120);
    cfg(3, 8'h01);
    cfgPtrLoWe = 1; cfgData = 8'h40;
    access(0, 8'h00, 0, 0);
    cfgPtrLoWe = 0;
    chk("R11 access uses old pointer", gotAddr, 12'h120);
    access(0, 8'h00, 0, 0);
    chk("R11 next access uses new pointer", gotAddr, 12'h140);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_banked();
    t_window();
    t_wrap();
    t_fixed();
    t_data();
    t_idle();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule